// File: doc/BRIEF.md
# Flash Access Gate

This block stands between a processor bus port and a flash array model. It takes one request at a time over a valid/ready bus and sorts its address into the main array, the option-byte alias window, the boot-loader information block, or an unmapped hole. It rewrites alias addresses onto the last main page, which holds the option bytes. It then passes the access on to the array or refuses it.

Reads are allowed in all three mapped regions. Program and erase requests are checked against protection state. Each main page below the last has its own protection bit. The last page, whether reached directly or through the alias, is guarded by a separate option-byte bit. The information block can never be written. Refused requests finish in one cycle with an error flag and never strobe the array. A read takes one cycle plus a wait count from a 3-bit configuration input. That count is captured when the request is accepted and saturates at 2. The number of main pages is a parameter. The option-byte page is always the last page present.

Top module: `flash_gate`

## Requirements
- R1: A read in the main array (address below NUM_PAGES x 1 KB) presents byte address `req_addr[16:0]` on `flash_addr` with `flash_info` low. It returns `flash_rdata` on `rsp_rdata` with `rsp_err` low.
- R2: An access in 0x1FF0_0000 to 0x1FF0_03FF is sent to the last main page, at `flash_addr` = (NUM_PAGES-1) x 1024 + `req_addr[9:0]`.
- R3: A read in 0x1F00_0000 to 0x1F00_07FF succeeds with `flash_info` high and `flash_addr` = `req_addr[10:0]`.
- R4: A program (`req_op`=01) or erase (`req_op`=10) to the information block gets `rsp_err` high and never raises `flash_en`.
- R5: A program or erase to main page p < NUM_PAGES-1, where p = `req_addr[16:10]`, is refused with `rsp_err` exactly when `page_prot[p]` is 1. Otherwise it strobes `flash_en` for one cycle with `flash_op` equal to `req_op`.
- R6: Program or erase to the last page, by its direct address or through the alias, is refused exactly when `opt_prot` is 1, whatever `page_prot` holds.
- R7: Any address outside the three regions gives `rsp_err` on read and on write, with no `flash_en`.
- R8: A permitted read gives `rsp_valid` min(`wait_cfg`,2)+1 cycles after the accepting clock edge, and holds `flash_en` and `flash_addr` steady until then. Writes and refused requests respond 1 cycle after acceptance.
- R9: The wait count is taken from `wait_cfg` at the accepting edge. Later changes do not alter a read in progress.
- R10: After reset `req_ready` is 1 and `rsp_valid` and `flash_en` are 0. Only one request is outstanding, and `req_ready` is 1 again in the cycle after a response.
- R11: The reserved operation code `req_op`=11 is refused with `rsp_err` at any address, without `flash_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Gate idle, request accepted this cycle |
| req_op | input | 2 | 00 read, 01 program, 10 erase, 11 reserved |
| req_addr | input | 32 | Bus byte address |
| req_wdata | input | 32 | Program data |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Request refused |
| rsp_rdata | output | 32 | Read data, zero when not a good read |
| page_prot | input | NUM_PAGES-1 | Protection bit per main page below the last |
| opt_prot | input | 1 | Protection bit of the option-byte page |
| wait_cfg | input | 3 | Read wait count, values above 2 act as 2 |
| flash_en | output | 1 | Array access strobe |
| flash_op | output | 2 | Operation code passed to the array |
| flash_info | output | 1 | Selects the information block |
| flash_addr | output | 17 | Physical byte address in the array |
| flash_wdata | output | 32 | Program data to the array |
| flash_rdata | input | 32 | Read data from the array |

## Verification
Reads are issued at main, alias and information addresses with wait settings 0, 1, 2 and 5. The address on the array port tells apart a correct remap from a passed-through address, and the response cycle tells saturation apart from raw use of the field. Program and erase requests are swept over a page with its bit set, a clear neighbour, and the last page under opposite states of the page vector and the option bit. This shows which bit guards which page. Unmapped, reserved-op and mid-read configuration changes separate early refusal and latched wait counts from late or live ones.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

    localparam int PAGE_LOG2 = 10;
    localparam int PHYS_W    = 17;
    localparam int MAX_WAIT  = 2;

    localparam logic [31:0] ALIAS_BASE = 32'h1FF0_0000;
    localparam logic [31:0] INFO_BASE  = 32'h1F00_0000;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        RG_NONE  = 2'd0,
        RG_MAIN  = 2'd1,
        RG_ALIAS = 2'd2,
        RG_INFO  = 2'd3
    } region_e;

    typedef struct packed {
        region_e             region;
        logic [PHYS_W-1:0]   phys;
    } dec_t;

    typedef struct packed {
        op_e                 op;
        logic                err;
        logic                info;
        logic [PHYS_W-1:0]   phys;
        logic [1:0]          wcnt;
    } acc_t;

    function automatic logic [1:0] clamp_wait(input logic [2:0] w);
        return (w > 3'(MAX_WAIT)) ? 2'(MAX_WAIT) : w[1:0];
    endfunction

    function automatic logic is_write(input op_e op);
        return (op == OP_PROG) || (op == OP_ERASE);
    endfunction

endpackage

// File: rtl/fg_decode.sv
module fg_decode
    import flash_gate_pkg::*;
#(
    parameter int NUM_PAGES = 128
) (
    input  logic [31:0] addr,
    output dec_t        dec
);
    localparam logic [31:0] MAIN_BYTES = 32'(NUM_PAGES) << PAGE_LOG2;
    localparam logic [PHYS_W-1:0] LAST_BASE = PHYS_W'(NUM_PAGES - 1) << PAGE_LOG2;

    always_comb begin
        dec.region = RG_NONE;
        dec.phys   = '0;
        if (addr < MAIN_BYTES) begin
            dec.region = RG_MAIN;
            dec.phys   = addr[PHYS_W-1:0];
        end else if (addr[31:PAGE_LOG2] == ALIAS_BASE[31:PAGE_LOG2]) begin
            dec.region = RG_ALIAS;
            dec.phys   = LAST_BASE | PHYS_W'(addr[PAGE_LOG2-1:0]);
        end else if (addr[31:PAGE_LOG2+1] == INFO_BASE[31:PAGE_LOG2+1]) begin
            dec.region = RG_INFO;
            dec.phys   = PHYS_W'(addr[PAGE_LOG2:0]);
        end
    end
endmodule

// File: rtl/fg_protect.sv
module fg_protect
    import flash_gate_pkg::*;
#(
    parameter int NUM_PAGES = 128,
    localparam int PG_W     = $clog2(NUM_PAGES)
) (
    input  region_e              region,
    input  op_e                  op,
    input  logic [PG_W-1:0]      page,
    input  logic [NUM_PAGES-2:0] page_prot,
    input  logic                 opt_prot,
    output logic                 deny
);
    logic [NUM_PAGES-1:0] prot_all;
    logic                 wr;

    assign prot_all = {opt_prot, page_prot};
    assign wr       = is_write(op);

    always_comb begin
        if (op == OP_RSVD) begin
            deny = 1'b1;
        end else begin
            unique case (region)
                RG_MAIN:  deny = wr && prot_all[page];
                RG_ALIAS: deny = wr && prot_all[NUM_PAGES-1];
                RG_INFO:  deny = wr;
                default:  deny = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/fg_sequencer.sv
module fg_sequencer
    import flash_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  acc_t acc_in,
    output acc_t acc_q,
    output logic busy,
    output logic done
);
    logic [1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            acc_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                cnt   <= acc_in.wcnt;
                acc_q <= acc_in;
            end
        end else if (cnt == '0) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt - 2'd1;
        end
    end

    assign done = busy && (cnt == '0);

    a_r8_count_steps: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 2'd1))
        else $error("wait count did not step down by one");

    a_r9_access_held: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(acc_q))
        else $error("latched access changed during wait");
endmodule

// File: rtl/flash_gate.sv
module flash_gate
    import flash_gate_pkg::*;
#(
    parameter int NUM_PAGES = 128,
    localparam int PG_W     = $clog2(NUM_PAGES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [31:0]          req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [31:0]          rsp_rdata,
    input  logic [NUM_PAGES-2:0] page_prot,
    input  logic                 opt_prot,
    input  logic [2:0]           wait_cfg,
    output logic                 flash_en,
    output logic [1:0]           flash_op,
    output logic                 flash_info,
    output logic [PHYS_W-1:0]    flash_addr,
    output logic [31:0]          flash_wdata,
    input  logic [31:0]          flash_rdata
);
    dec_t  dec;
    op_e   op_in;
    logic  deny;
    logic  accept;
    logic  busy;
    logic  done;
    acc_t  acc_in;
    acc_t  acc_q;
    logic [31:0] wdata_q;

    assign op_in = op_e'(req_op);

    fg_decode #(.NUM_PAGES(NUM_PAGES)) u_decode (
        .addr (req_addr),
        .dec  (dec)
    );

    fg_protect #(.NUM_PAGES(NUM_PAGES)) u_protect (
        .region    (dec.region),
        .op        (op_in),
        .page      (dec.phys[PAGE_LOG2 +: PG_W]),
        .page_prot (page_prot),
        .opt_prot  (opt_prot),
        .deny      (deny)
    );

    always_comb begin
        acc_in.op   = op_in;
        acc_in.err  = deny;
        acc_in.info = (dec.region == RG_INFO);
        acc_in.phys = dec.phys;
        acc_in.wcnt = (op_in == OP_READ && !deny) ? clamp_wait(wait_cfg) : 2'd0;
    end

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;

    fg_sequencer u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .acc_in (acc_in),
        .acc_q  (acc_q),
        .busy   (busy),
        .done   (done)
    );

    always_ff @(posedge clk) begin
        if (rst)         wdata_q <= '0;
        else if (accept) wdata_q <= req_wdata;
    end

    assign flash_en    = busy && !acc_q.err;
    assign flash_op    = acc_q.op;
    assign flash_info  = acc_q.info;
    assign flash_addr  = acc_q.phys;
    assign flash_wdata = wdata_q;

    assign rsp_valid = done;
    assign rsp_err   = done && acc_q.err;
    assign rsp_rdata = (done && !acc_q.err && acc_q.op == OP_READ) ? flash_rdata : 32'd0;

    a_r4_no_strobe_on_error: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> !flash_en)
        else $error("array strobed on refused request");

    a_r10_ready_after_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready)
        else $error("not ready after response");

    a_r8_strobe_steady: assert property (@(posedge clk) disable iff (rst)
        (flash_en && !rsp_valid) |=> (flash_en && $stable(flash_addr)))
        else $error("array strobe or address moved during wait");

    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!flash_en && !rsp_valid))
        else $error("activity while idle");
endmodule

// File: tb/flash_gate_tb.sv
module flash_gate_tb;
    localparam int NP = 128;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_op;
    logic [31:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic [NP-2:0] page_prot;
    logic        opt_prot;
    logic [2:0]  wait_cfg;
    logic        flash_en;
    logic [1:0]  flash_op;
    logic        flash_info;
    logic [16:0] flash_addr;
    logic [31:0] flash_wdata;
    logic [31:0] flash_rdata;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign flash_rdata = {flash_info ? 8'hB0 : 8'hA0, 7'd0, flash_addr};

    flash_gate #(.NUM_PAGES(NP)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .page_prot(page_prot), .opt_prot(opt_prot), .wait_cfg(wait_cfg),
        .flash_en(flash_en), .flash_op(flash_op), .flash_info(flash_info),
        .flash_addr(flash_addr), .flash_wdata(flash_wdata), .flash_rdata(flash_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_is_main(input logic [31:0] a);
        return a < 32'(NP * 1024);
    endfunction
    function automatic bit m_is_alias(input logic [31:0] a);
        return a >= 32'h1FF0_0000 && a <= 32'h1FF0_03FF;
    endfunction
    function automatic bit m_is_info(input logic [31:0] a);
        return a >= 32'h1F00_0000 && a <= 32'h1F00_07FF;
    endfunction

    function automatic bit m_err(input logic [1:0] op, input logic [31:0] a);
        bit wr = (op == 2'b01) || (op == 2'b10);
        int pg;
        if (op == 2'b11) return 1'b1;
        if (m_is_main(a)) begin
            pg = int'(a >> 10);
            if (pg == NP - 1) return wr && opt_prot;
            return wr && page_prot[pg];
        end
        if (m_is_alias(a)) return wr && opt_prot;
        if (m_is_info(a))  return wr;
        return 1'b1;
    endfunction

    function automatic logic [16:0] m_phys(input logic [31:0] a);
        if (m_is_alias(a)) return 17'((NP - 1) * 1024 + int'(a & 32'h3FF));
        if (m_is_info(a))  return 17'(a & 32'h7FF);
        return a[16:0];
    endfunction

    task automatic req(input logic [1:0] op, input logic [31:0] a, input int wcfg,
                       input int wnew, input string tag);
        bit e;
        int lat;
        logic [16:0] ph;
        wait_cfg  = 3'(wcfg);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = a ^ 32'h5A5A_0000;
        e   = m_err(op, a);
        ph  = m_phys(a);
        lat = (op == 2'b00 && !e) ? ((wcfg > 2) ? 2 : wcfg) + 1 : 1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        wait_cfg  = 3'(wnew);
        for (int c = 0; c < lat; c++) begin
            @(negedge clk);
            chk(flash_en == !e, {tag, " strobe"}, 64'(flash_en), 64'(!e));
            if (!e) begin
                chk(flash_addr == ph, {tag, " addr"}, 64'(flash_addr), 64'(ph));
                chk(flash_info == m_is_info(a), {tag, " info"}, 64'(flash_info), 64'(m_is_info(a)));
                chk(flash_op == op, {tag, " op"}, 64'(flash_op), 64'(op));
            end
            chk(rsp_valid == (c == lat - 1), {tag, " rsp timing"}, 64'(rsp_valid), 64'(c == lat - 1));
            if (c == lat - 1) begin
                chk(rsp_err == e, {tag, " err"}, 64'(rsp_err), 64'(e));
                if (!e && op == 2'b00)
                    chk(rsp_rdata == {m_is_info(a) ? 8'hB0 : 8'hA0, 7'd0, ph},
                        {tag, " rdata"}, 64'(rsp_rdata),
                        64'({m_is_info(a) ? 8'hB0 : 8'hA0, 7'd0, ph}));
                if (!e && op != 2'b00)
                    chk(flash_wdata == (a ^ 32'h5A5A_0000), {tag, " wdata"},
                        64'(flash_wdata), 64'(a ^ 32'h5A5A_0000));
            end
        end
        @(negedge clk);
        chk(req_ready && !rsp_valid && !flash_en, {tag, " R10 idle"},
            64'({req_ready, rsp_valid, flash_en}), 64'(3'b100));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_wdata = '0;
        page_prot = '0; opt_prot = 1'b0; wait_cfg = 3'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 reset ready", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R10 reset rsp", 64'(rsp_valid), 64'd0);
        chk(flash_en == 1'b0, "R10 reset strobe", 64'(flash_en), 64'd0);

        req(2'b00, 32'h0000_0C14, 0, 0, "R1 main read w0");
        req(2'b00, 32'h0001_2344, 1, 1, "R1 R8 main read w1");
        req(2'b00, 32'h0000_0008, 2, 2, "R8 main read w2");
        req(2'b00, 32'h0001_7FFC, 5, 5, "R8 main read w5 saturates");
        req(2'b00, 32'h0001_7FFC, 7, 0, "R8 main read w7 saturates");

        req(2'b00, 32'h1FF0_0123, 0, 0, "R2 alias read");
        req(2'b00, 32'h1FF0_03FF, 1, 1, "R2 alias read top");
        req(2'b01, 32'h1FF0_0010, 0, 0, "R2 R6 alias program open");
        opt_prot = 1'b1;
        req(2'b10, 32'h1FF0_0010, 0, 0, "R6 alias erase guarded");
        opt_prot = 1'b0;

        req(2'b00, 32'h1F00_07F0, 1, 1, "R3 info read");
        req(2'b01, 32'h1F00_0004, 0, 0, "R4 info program");
        req(2'b10, 32'h1F00_0400, 0, 0, "R4 info erase");

        page_prot[5] = 1'b1;
        req(2'b01, 32'h0000_1400, 0, 0, "R5 program protected page 5");
        req(2'b10, 32'h0000_17FC, 0, 0, "R5 erase protected page 5");
        req(2'b01, 32'h0000_1800, 0, 0, "R5 program open page 6");
        req(2'b00, 32'h0000_1404, 0, 0, "R5 read protected page 5");

        page_prot = '1;
        req(2'b10, 32'h0001_FC00, 0, 0, "R6 last page open despite page vector");
        page_prot = '0;
        opt_prot  = 1'b1;
        req(2'b01, 32'h0001_FC20, 0, 0, "R6 last page guarded by option bit");
        req(2'b01, 32'h0001_F800, 0, 0, "R6 page 126 unaffected by option bit");
        opt_prot = 1'b0;

        req(2'b00, 32'h0002_0000, 0, 0, "R7 unmapped read above main");
        req(2'b01, 32'h4000_0000, 0, 0, "R7 unmapped program");
        req(2'b00, 32'h1FF0_0400, 2, 2, "R7 read past alias");
        req(2'b00, 32'h1F00_0800, 2, 2, "R7 read past info");

        req(2'b11, 32'h0000_0100, 0, 0, "R11 reserved op main");
        req(2'b11, 32'h1F00_0000, 2, 2, "R11 reserved op info");

        req(2'b00, 32'h0000_2000, 2, 0, "R9 wait lowered mid read");
        req(2'b00, 32'h0000_2004, 0, 2, "R9 wait raised mid read");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule